// File: doc/BRIEF.md
# Serial-to-Parallel Receiver with Word Boundary Slip

This block turns one serial data line into parallel words. Bits are captured on a fast bit clock, either on the rising edge only (single data rate) or on both edges (double data rate). A word strobe marks each word period; on every strobe, the block presents the most recent bits as a word of a selectable width. The earliest bit of the word sits in the most significant position. Output bits above the selected width are held at zero.

A receiver does not know at first where a word starts in the serial stream. To align to a known training pattern, logic downstream issues single-cycle slip requests until the output matches the pattern. In single data rate mode each slip moves the word window one bit later in the stream. In double data rate mode successive slips alternate between one bit earlier and three bits later. With an 8-bit repeating pattern, eight slips bring back the starting alignment. A slip is locked out until the next word has been produced, so a burst of requests moves the boundary only once.

Top module: `deser_bitslip`

## Requirements
- R1: With `mode`=0 (single data rate), `din` is sampled on each rising edge of `clk`, and `width` (the bit count, 2 to 8) sets the word size.
- R2: With `mode`=1 (double data rate), `din` is sampled on both clock edges, with the rising-edge bit ahead of the following falling-edge bit in stream order. `width` may be 4, 6 or 8.
- R3: `dout` changes only on a rising edge where `word_stb` is high. It then holds the last `width` stream bits, earliest bit in `dout[width-1]` and latest in `dout[0]`.
- R4: Bits of `dout` at positions `width` and above are always zero.
- R5: In single data rate mode, each accepted slip moves the window one bit later, so a repeating pattern rotates left by one. After `width` slips the starting word returns.
- R6: In double data rate mode, accepted slips alternate: the first rotates the repeating pattern right by one and the second rotates it left by three. After `width` slips the starting word returns.
- R7: After an accepted slip, further `bitslip` pulses are ignored until the next `word_stb` edge. An ignored pulse changes neither the alignment nor the alternation step.
- R8: An active-low `rst_n` clears `dout`, the captured bits, the alignment and the alternation step, so the first double data rate slip after reset is always the rotate-right-by-one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | 0 = single data rate, 1 = double data rate |
| width | input | 4 | Word size in bits |
| din | input | 1 | Serial data |
| word_stb | input | 1 | Word strobe, one cycle high per word period |
| bitslip | input | 1 | Single-cycle slip request |
| dout | output | 8 | Parallel word, earliest bit most significant |

## Verification
A word is visible on `dout` just after the rising edge that samples `word_stb` high, so the bench reads it one nanosecond after that edge. It then compares it with a rotation of the repeating pattern, computed arithmetically in the bench. A slip sampled on or before a strobe edge takes effect no later than the word after that strobe. Each slip check therefore runs two full word periods and judges the second word. Every period keeps the strobe cadence exact, so the stream phase stays fixed from word to word. The sweep covers all ten legal mode and width pairs.

// File: rtl/deser_pkg.sv
package deser_pkg;
  typedef enum logic {
    CAP_SDR = 1'b0,
    CAP_DDR = 1'b1
  } cap_mode_e;
endpackage

// File: rtl/deser_capture.sv
module deser_capture
  import deser_pkg::*;
#(
  parameter int unsigned HIST_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cap_mode_e         mode,
  input  logic              din,
  output logic [HIST_W-1:0] hist
);
  logic              fall_q;
  logic              rise_q;
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  // falling-edge sample, used only in double data rate
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= din;
  end

  always_comb begin
    if (mode == CAP_DDR) hist_d = {hist_q[HIST_W-3:0], rise_q, fall_q};
    else                 hist_d = {hist_q[HIST_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      rise_q <= 1'b0;
    end else begin
      hist_q <= hist_d;
      rise_q <= din;
    end
  end

  assign hist = hist_q;
endmodule

// File: rtl/deser_slip_ctrl.sv
module deser_slip_ctrl
  import deser_pkg::*;
#(
  parameter int unsigned WSEL_W = 4,
  parameter int unsigned OFS_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cap_mode_e         mode,
  input  logic [WSEL_W-1:0] width,
  input  logic              word_stb,
  input  logic              bitslip,
  output logic [OFS_W-1:0]  ofs,
  output logic              phase,
  output logic              busy
);
  localparam logic [WSEL_W-1:0] ONE   = WSEL_W'(1);
  localparam logic [WSEL_W-1:0] THREE = WSEL_W'(3);

  logic [OFS_W-1:0]  ofs_q, ofs_d;
  logic              phase_q, phase_d;
  logic              busy_q, busy_d;
  logic              take;
  logic [WSEL_W-1:0] cur, inc1, dec1, dec3, step;

  assign take = bitslip & ~busy_q;
  assign cur  = WSEL_W'(ofs_q);

  always_comb begin
    inc1 = ((cur + ONE) == width) ? '0 : cur + ONE;     // window one bit earlier
    dec1 = (cur == '0) ? width - ONE : cur - ONE;        // one bit later
    dec3 = (cur >= THREE) ? cur - THREE : cur + width - THREE; // three bits later
    if (mode == CAP_DDR) step = phase_q ? dec3 : inc1;
    else                 step = dec1;

    ofs_d   = take ? OFS_W'(step) : ofs_q;
    phase_d = (take && mode == CAP_DDR) ? ~phase_q : phase_q;
    if (take)          busy_d = 1'b1;
    else if (word_stb) busy_d = 1'b0;
    else               busy_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q   <= '0;
      phase_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      ofs_q   <= ofs_d;
      phase_q <= phase_d;
      busy_q  <= busy_d;
    end
  end

  assign ofs   = ofs_q;
  assign phase = phase_q;
  assign busy  = busy_q;
endmodule

// File: rtl/deser_word_sel.sv
module deser_word_sel #(
  parameter int unsigned MAX_W  = 8,
  parameter int unsigned HIST_W = 16,
  parameter int unsigned WSEL_W = 4,
  parameter int unsigned OFS_W  = 3
) (
  input  logic [HIST_W-1:0] hist,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [WSEL_W-1:0] width,
  output logic [MAX_W-1:0]  word
);
  logic [HIST_W-1:0] shifted;

  assign shifted = hist >> ofs;

  for (genvar i = 0; i < MAX_W; i++) begin : g_bit
    assign word[i] = (WSEL_W'(i) < width) & shifted[i];
  end
endmodule

// File: rtl/deser_bitslip.sv
module deser_bitslip
  import deser_pkg::*;
#(
  parameter int unsigned MAX_W  = 8,
  parameter int unsigned WSEL_W = $clog2(MAX_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic [WSEL_W-1:0] width,
  input  logic              din,
  input  logic              word_stb,
  input  logic              bitslip,
  output logic [MAX_W-1:0]  dout
);
  localparam int unsigned HIST_W = 2 * MAX_W;
  localparam int unsigned OFS_W  = $clog2(MAX_W);

  cap_mode_e         mode_e;
  logic [HIST_W-1:0] hist;
  logic [OFS_W-1:0]  ofs;
  logic              slip_phase;
  logic              slip_busy;
  logic [MAX_W-1:0]  word;
  logic [MAX_W-1:0]  dout_q, dout_d;

  assign mode_e = cap_mode_e'(mode);

  deser_capture #(.HIST_W(HIST_W)) u_cap (
    .clk  (clk),
    .rst_n(rst_n),
    .mode (mode_e),
    .din  (din),
    .hist (hist)
  );

  deser_slip_ctrl #(.WSEL_W(WSEL_W), .OFS_W(OFS_W)) u_slip (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_e),
    .width   (width),
    .word_stb(word_stb),
    .bitslip (bitslip),
    .ofs     (ofs),
    .phase   (slip_phase),
    .busy    (slip_busy)
  );

  deser_word_sel #(
    .MAX_W(MAX_W), .HIST_W(HIST_W), .WSEL_W(WSEL_W), .OFS_W(OFS_W)
  ) u_sel (
    .hist (hist),
    .ofs  (ofs),
    .width(width),
    .word (word)
  );

  always_comb dout_d = word_stb ? word : dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= dout_d;
  end

  assign dout = dout_q;
endmodule

// File: rtl/deser_bitslip_chk.sv
module deser_bitslip_chk #(
  parameter int unsigned MAX_W  = 8,
  parameter int unsigned WSEL_W = 4,
  parameter int unsigned OFS_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode,
  input logic [WSEL_W-1:0] width,
  input logic              word_stb,
  input logic              bitslip,
  input logic [MAX_W-1:0]  dout,
  input logic [OFS_W-1:0]  ofs,
  input logic              phase,
  input logic              busy
);
  // R4: nothing above the selected width
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dout >> width) == '0);

  // R3: the word only moves on a strobe edge
  a_r3_hold_between_words: assert property (@(posedge clk) disable iff (!rst_n)
    !word_stb |=> $stable(dout));

  // R1: the alignment offset stays inside the word
  a_r1_offset_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    WSEL_W'(ofs) < width);

  // R7: a locked-out request leaves alignment and step untouched
  a_r7_ignore_while_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bitslip |=> $stable(ofs) && $stable(phase));

  // R7: an accepted request starts the lockout
  a_r7_lock_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && bitslip |=> busy);

  // R6: accepted requests in double data rate alternate the step
  a_r6_ddr_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && bitslip && mode |=> phase != $past(phase));

  // R5: single data rate never advances the alternation step
  a_r5_sdr_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |=> $stable(phase));
endmodule

bind deser_bitslip deser_bitslip_chk #(
  .MAX_W(MAX_W), .WSEL_W(WSEL_W), .OFS_W(OFS_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode    (mode),
  .width   (width),
  .word_stb(word_stb),
  .bitslip (bitslip),
  .dout    (dout),
  .ofs     (ofs),
  .phase   (slip_phase),
  .busy    (slip_busy)
);

// File: tb/test_deser_bitslip.sv
module test_deser_bitslip;
  logic       clk;
  logic       rst_n;
  logic       mode;
  logic [3:0] width;
  logic       din;
  logic       word_stb;
  logic       bitslip;
  logic [7:0] dout;

  int         n_tests = 0;
  int         n_fail  = 0;
  int         cfg_w   = 8;
  int         per     = 8;
  int         sidx    = 0;
  logic [7:0] pat     = 8'h81;
  logic [7:0] got     = 8'h00;
  logic       ph      = 1'b0;

  deser_bitslip i_deser_bitslip (
    .clk(clk), .rst_n(rst_n), .mode(mode), .width(width), .din(din),
    .word_stb(word_stb), .bitslip(bitslip), .dout(dout)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s mode=%0d width=%0d: actual %02h expected %02h",
               req, mode, cfg_w, act, exp);
    end
  endtask

  function automatic logic [7:0] rotl(input logic [7:0] x, input int n, input int w);
    logic [7:0] m;
    m = 8'((16'd1 << w) - 16'd1);
    return ((x << n) | (x >> (w - n))) & m;
  endfunction

  task automatic drive_bit();
    din = pat[cfg_w - 1 - (sidx % cfg_w)];
    sidx++;
  endtask

  // serial source: rising-edge bit set at +7, falling-edge bit at +2
  initial begin
    din = 1'b0;
    forever begin
      @(posedge clk);
      #2;
      if (mode) drive_bit();
      #5;
      drive_bit();
    end
  end

  // one word period with exact cadence; got = word of the previous strobe
  task automatic word(input int nslip);
    for (int c = 0; c < per; c++) begin
      @(posedge clk);
      #1;
      if (c == 0) got = dout;
      word_stb = (c == per - 1);
      bitslip  = (c < nslip);
    end
  endtask

  function automatic logic [7:0] next_exp(input logic [7:0] x);
    if (mode) return ph ? rotl(x, 3, cfg_w) : rotl(x, cfg_w - 1, cfg_w);
    return rotl(x, 1, cfg_w);
  endfunction

  task automatic do_reset(input logic m, input int w);
    rst_n = 1'b0; word_stb = 1'b0; bitslip = 1'b0;
    mode = m; cfg_w = w; width = 4'(w);
    per = m ? w / 2 : w;
    pat = (w >= 4) ? 8'(((1 << (w - 1)) | 1)) : 8'(1 << (w - 1));
    sidx = 0; ph = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset clears word", dout, 8'h00);
    rst_n = 1'b1;
  endtask

  task automatic run_cfg(input logic m, input int w);
    logic [7:0] w0, exp, match;
    do_reset(m, w);
    repeat (4) word(0);
    w0 = got;
    match = pat;
    for (int r = 0; r < w; r++) if (rotl(pat, r, w) == w0) match = w0;
    chk(m ? "R2 ddr word is pattern rotation" : "R1 sdr word is pattern rotation", w0, match);
    chk("R4 upper bits zero", w0 & ~8'(((16'd1 << w) - 16'd1)), 8'h00);
    word(0);
    chk("R3 steady word repeats", got, w0);
    exp = w0;
    for (int j = 1; j <= w; j++) begin
      word(1);
      word(0);
      exp = next_exp(exp);
      if (m) ph = ~ph;
      chk(m ? "R6 ddr slip step" : "R5 sdr slip step", got, exp);
    end
    chk(m ? "R6 ddr full slip cycle restores" : "R5 sdr full slip cycle restores", got, w0);
    word(2);
    word(0);
    exp = next_exp(exp);
    if (m) ph = ~ph;
    chk("R7 second request ignored", got, exp);
    word(1);
    word(0);
    exp = next_exp(exp);
    if (m) ph = ~ph;
    chk("R7 step sequence undisturbed", got, exp);
    // leave the step odd, then reset and expect the first step again
    word(1);
    do_reset(m, w);
    repeat (4) word(0);
    w0 = got;
    word(1);
    word(0);
    chk("R8 first slip after reset", got, m ? rotl(w0, w - 1, w) : rotl(w0, 1, w));
  endtask

  initial begin
    rst_n = 1'b0; mode = 1'b0; width = 4'd8; word_stb = 1'b0; bitslip = 1'b0;
    for (int w = 2; w <= 8; w++) run_cfg(1'b0, w);
    for (int w = 4; w <= 8; w += 2) run_cfg(1'b1, w);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule